// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog for an always-on power domain. A single up-counter advances by one on every clock while the watchdog is enabled. It is compared against two independent thresholds. Crossing the first (warning) threshold sets a sticky status bit that drives an interrupt pin. Crossing the second (final) threshold drives a reset-request pin, which the system reset controller acts on.

Software services the watchdog through a small register port with a write strobe, an address, write data and combinational read data. A pause option, when selected, freezes the counter while the sleep indication input is high. A one-way lock protects the control, count and threshold registers once software has finished configuring them.

Top module: `wdt_bark_bite`

## Requirements
- R1: After reset the control register reads 0, the lock reads 1, the count reads 0, both thresholds read all-ones, the status reads 0, and `irq_o` and `rst_req_o` are 0.
- R2: While enabled and not paused, the count rises by exactly one on every clock. It saturates at all-ones rather than wrapping.
- R3: When the enable bit (control bit 0) is 0, the count holds its value.
- R4: When the pause bit (control bit 1) is 1 and `sleep_i` is high, the count holds its value. Counting resumes when `sleep_i` falls.
- R5: On each clock where the watchdog is enabled and count >= warning threshold, the status bit is set. `irq_o` follows the status bit one clock later. Starting from count s with the block enabled, `irq_o` is first high max(warn - s, 0) + 2 clocks after the enabling write.
- R6: On each clock where the watchdog is enabled and count >= final threshold, the reset-request state is set. `rst_req_o` follows that state one clock later, after max(final - s, 0) + 2 clocks by the same count as R5. The state stays set until reset, or until an accepted count write with a value below the final threshold clears it.
- R7: Writing 1 in bit 0 at address 5 clears the status bit, and reading address 5 returns the status in bit 0. Writing 1 in bit 0 at address 6 sets the status bit. Both work regardless of the lock.
- R8: The lock (address 1, bit 0) is cleared by writing 0 and cannot be set again by software. While it is 0, writes to control, count and both thresholds are ignored.
- R9: Register addresses are 0 for control, 1 for lock, 2 for count, 3 for the warning threshold, 4 for the final threshold, 5 for status and 6 for status-test. Unused bits and address 6 read as 0.
- R10: An accepted count write takes priority over the increment in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_i | input | 1 | Sleep indication; pauses counting when the pause bit is set |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Register read data for `reg_addr` |
| irq_o | output | 1 | Warning interrupt |
| rst_req_o | output | 1 | Reset request |

## Verification
The assertions assume that `reg_addr` and `reg_we` are known and stable around each clock edge, and that the count register is changed only through accepted writes. The bench drives every input on the falling edge and holds it through the next rising edge, so these assumptions hold. The bench also makes each count write land while the watchdog is disabled or in a known phase, so the timing from the enabling write is exact.

// File: rtl/wdt_bark_bite.sv
module wdt_bark_bite #(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_i,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  output logic          irq_o,
  output logic          rst_req_o
);
  localparam logic [W-1:0]  CNT_MAX = {W{1'b1}};
  localparam logic [AW-1:0] A_CTRL  = AW'(0);
  localparam logic [AW-1:0] A_LOCK  = AW'(1);
  localparam logic [AW-1:0] A_COUNT = AW'(2);
  localparam logic [AW-1:0] A_WARN  = AW'(3);
  localparam logic [AW-1:0] A_FINAL = AW'(4);
  localparam logic [AW-1:0] A_STAT  = AW'(5);
  localparam logic [AW-1:0] A_TEST  = AW'(6);

  logic         en_q, pause_q, lock_q, bark_stat, bite_stat;
  logic [W-1:0] cnt_q, bark_q, bite_q;

  wire wr_ctrl  = reg_we && reg_addr == A_CTRL  && lock_q;
  wire wr_cnt   = reg_we && reg_addr == A_COUNT && lock_q;
  wire wr_warn  = reg_we && reg_addr == A_WARN  && lock_q;
  wire wr_final = reg_we && reg_addr == A_FINAL && lock_q;
  wire clr_stat = reg_we && reg_addr == A_STAT  && reg_wdata[0];
  wire set_stat = reg_we && reg_addr == A_TEST  && reg_wdata[0];
  wire clr_lock = reg_we && reg_addr == A_LOCK  && !reg_wdata[0];

  wire run      = en_q && !(pause_q && sleep_i);
  wire bark_hit = en_q && cnt_q >= bark_q;
  wire bite_hit = en_q && cnt_q >= bite_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      pause_q <= 1'b0;
      lock_q  <= 1'b1;
      bark_q  <= CNT_MAX;
      bite_q  <= CNT_MAX;
    end else begin
      if (wr_ctrl) begin
        en_q    <= reg_wdata[0];
        pause_q <= reg_wdata[1];
      end
      if (clr_lock) lock_q <= 1'b0;
      if (wr_warn)  bark_q <= reg_wdata;
      if (wr_final) bite_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (wr_cnt)                cnt_q <= reg_wdata;
    else if (run && cnt_q != CNT_MAX) cnt_q <= cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bark_stat <= 1'b0;
      bite_stat <= 1'b0;
      irq_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      bark_stat <= bark_hit | set_stat | (bark_stat & ~clr_stat);
      if (wr_cnt && reg_wdata < bite_q) bite_stat <= 1'b0;
      else if (bite_hit)                bite_stat <= 1'b1;
      irq_o     <= bark_stat;
      rst_req_o <= bite_stat;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata[1:0] = {pause_q, en_q};
      A_LOCK:  reg_rdata[0]   = lock_q;
      A_COUNT: reg_rdata      = cnt_q;
      A_WARN:  reg_rdata      = bark_q;
      A_FINAL: reg_rdata      = bite_q;
      A_STAT:  reg_rdata[0]   = bark_stat;
      default: reg_rdata      = '0;
    endcase
  end
endmodule

module wdt_bark_bite_chk #(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sleep_i,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic          lock_q,
  input logic          en_q,
  input logic          pause_q,
  input logic [W-1:0]  cnt_q,
  input logic [W-1:0]  bark_q,
  input logic [W-1:0]  bite_q,
  input logic          bark_stat,
  input logic          bite_stat,
  input logic          irq_o,
  input logic          rst_req_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  wire cnt_wr  = reg_we && reg_addr == AW'(2) && lock_q;
  wire ctrl_wr = reg_we && reg_addr == AW'(0);

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q |=> !lock_q);
  assert_locked_ctrl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && ctrl_wr) |=> ($stable(en_q) && $stable(pause_q)));
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !(pause_q && sleep_i) && !cnt_wr && cnt_q != MAXV) |=> cnt_q == $past(cnt_q) + W'(1));
  assert_disabled_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !cnt_wr) |=> $stable(cnt_q));
  assert_pause_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && pause_q && sleep_i && !cnt_wr) |=> $stable(cnt_q));
  assert_bark_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cnt_q >= bark_q) |=> bark_stat);
  assert_irq_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bark_stat) |=> irq_o);
  assert_bite_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bite_stat && !cnt_wr) |=> bite_stat);
  assert_bite_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cnt_q >= bite_q && !cnt_wr) |=> bite_stat);
  assert_rst_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bite_stat) |=> rst_req_o);
endmodule

bind wdt_bark_bite wdt_bark_bite_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .reg_we(reg_we), .reg_addr(reg_addr),
  .lock_q(lock_q), .en_q(en_q), .pause_q(pause_q), .cnt_q(cnt_q), .bark_q(bark_q),
  .bite_q(bite_q), .bark_stat(bark_stat), .bite_stat(bite_stat), .irq_o(irq_o),
  .rst_req_o(rst_req_o)
);

// File: tb/wdt_bark_bite_test.sv
module wdt_bark_bite_test;
  localparam int W  = 16;
  localparam int AW = 3;
  localparam int NV = 10;
  // start count, warning threshold, final threshold, clocks waited, expected irq, expected reset request
  localparam int VEC [NV][6] = '{
    '{0, 5, 10, 6, 0, 0}, '{0, 5, 10, 7, 1, 0}, '{0, 5, 10, 11, 1, 0},
    '{0, 5, 10, 12, 1, 1}, '{8, 5, 10, 2, 1, 0}, '{8, 5, 10, 4, 1, 1},
    '{20, 5, 10, 3, 1, 1}, '{2, 3, 4, 1, 0, 0}, '{2, 3, 4, 3, 1, 0},
    '{2, 3, 4, 4, 1, 1}};

  logic clk = 1'b0, rst_n = 1'b0, sleep_i = 1'b0, reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [W-1:0]  reg_wdata = '0, reg_rdata;
  logic          irq_o, rst_req_o;
  int errors = 0, checks = 0;
  logic [W-1:0] v;

  always #2 clk = ~clk;

  wdt_bark_bite #(.W(W), .AW(AW)) uut (.*);

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = W'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [W-1:0] d);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 R9 reset values
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 lock", v, 1);
    rd(2, v); chk("R1 count", v, 0);
    rd(3, v); chk("R1 warn", v, 16'hFFFF);
    rd(4, v); chk("R9 final", v, 16'hFFFF);
    rd(5, v); chk("R1 status", v, 0);
    rd(6, v); chk("R9 test reads 0", v, 0);
    chk("R1 irq", W'(irq_o), 0);
    chk("R1 rst_req", W'(rst_req_o), 0);

    for (int i = 0; i < NV; i++) begin
      wr(0, 0); wr(3, VEC[i][1]); wr(4, VEC[i][2]); wr(2, VEC[i][0]); wr(5, 1); wr(0, 1);
      repeat (VEC[i][3]) @(negedge clk);
      chk("R5 irq timing", W'(irq_o), W'(VEC[i][4]));
      chk("R6 rst timing", W'(rst_req_o), W'(VEC[i][5]));
    end

    // R2 saturation
    wr(0, 0); wr(3, 16'hFFFF); wr(4, 16'hFFFF); wr(2, 16'hFFFD); wr(5, 1); wr(0, 1);
    repeat (5) @(negedge clk);
    rd(2, v); chk("R2 saturate", v, 16'hFFFF);
    wr(0, 0);
    rd(2, v); chk("R2 saturate hold", v, 16'hFFFF);
    chk("R6 rst at max", W'(rst_req_o), 1);
    // R6 sticky, cleared by count write below final threshold
    wr(5, 1); @(negedge clk);
    chk("R6 sticky after status clear", W'(rst_req_o), 1);
    wr(2, 0); @(negedge clk);
    chk("R6 cleared by count write", W'(rst_req_o), 0);

    // R4 pause in sleep
    wr(0, 3); sleep_i = 1'b1; wr(2, 50);
    rd(2, v); chk("R4 paused start", v, 50);
    repeat (4) @(negedge clk);
    rd(2, v); chk("R4 paused hold", v, 50);
    sleep_i = 1'b0;
    repeat (3) @(negedge clk);
    rd(2, v); chk("R2 resume after sleep", v, 53);
    // R3 disable holds count
    wr(0, 0);
    rd(2, v); chk("R3 disable value", v, 55);
    repeat (4) @(negedge clk);
    rd(2, v); chk("R3 disable hold", v, 55);

    // R10 count write wins over increment
    wr(0, 1); wr(2, 100);
    rd(2, v); chk("R10 write priority", v, 100);
    wr(0, 0);
    rd(2, v); chk("R3 stop value", v, 102);

    // R7 test set and clear
    wr(6, 1); @(negedge clk);
    chk("R7 test sets irq", W'(irq_o), 1);
    rd(5, v); chk("R7 status read", v, 1);
    wr(5, 1); @(negedge clk);
    chk("R7 clear irq", W'(irq_o), 0);
    rd(5, v); chk("R7 status cleared", v, 0);

    // R8 lock
    wr(1, 1); rd(1, v); chk("R8 lock write 1", v, 1);
    wr(1, 0); rd(1, v); chk("R8 lock cleared", v, 0);
    wr(1, 1); rd(1, v); chk("R8 lock stays clear", v, 0);
    wr(2, 7); rd(2, v); chk("R8 count write ignored", v, 102);
    wr(3, 9); rd(3, v); chk("R8 warn write ignored", v, 16'hFFFF);
    wr(0, 1); rd(0, v); chk("R8 ctrl write ignored", v, 0);
    repeat (3) @(negedge clk);
    rd(2, v); chk("R8 still stopped", v, 102);
    wr(6, 1); @(negedge clk);
    chk("R7 test works while locked", W'(irq_o), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule